// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block sits beside the receiver, transmitter and modem-status logic of a 16550-style UART. It collects seven interrupt causes and applies one enable bit to each. It then reports the single most urgent enabled cause as a 6-bit identification code, together with an active-high interrupt line. Event-type causes are held in sticky pending flags. Each flag is cleared by its own action: a read of the receive data register, a read of the line-status register, a read of the modem-status register, a read of the identification register, or an XON flow-control character seen by the receiver.

The receive-data and transmit-empty causes are level conditions. They are taken from either the single-register flags or the FIFO trigger comparisons, depending on whether the FIFOs are enabled. The FIFOs, the stale-data timer and the flow-character matcher live elsewhere; their results arrive here as event pulses and levels. Register strobes are one-cycle pulses. A read of the identification register returns the code present in that same cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `iid` is 6'b000001 and `irq` is 0.
- R2: `irq` is 1 exactly when `iid[0]` is 0.
- R3: Line-status code 6'b000110 has the highest priority. A framing/parity/break error pulse sets a flag that only `rd_data` clears. An overrun pulse sets a separate flag that only `rd_lsr` clears. The cause is pending while either flag is set.
- R4: A stale-data pulse raises code 6'b001100, which only `rd_data` clears. When both level-2 causes are pending it is reported ahead of receive data.
- R5: The receive-data cause (code 6'b000100) is a level. It follows `rx_ready` when `fifo_en` is 0 and follows `rx_above_trig` when `fifo_en` is 1.
- R6: The transmit cause (code 6'b000010, level 3) is a level. It follows `tx_hold_empty` when `fifo_en` is 0 and follows `tx_below_trig` when `fifo_en` is 1.
- R7: A modem-change pulse raises code 6'b000000 (level 4), which only `rd_msr` clears.
- R8: Code 6'b010000 (level 5) has two causes. An XOFF detection is cleared only by an XON detection. A special-character match is cleared by an `rd_iir` that returns 6'b010000. That read leaves a pending XOFF cause in place.
- R9: A 0-to-1 transition on any bit of `flow_pins` (bit 0 CTS, bit 1 RTS, bit 2 DSR, all active low) raises code 6'b100000 (lowest priority). An `rd_iir` that returns that code clears it.
- R10: `ien` bit 0 enables line status, bit 1 receive data, bit 2 transmit, bit 3 modem, bit 4 stale data, bit 5 XOFF/special, and bit 6 pin change. A disabled cause is never reported, but its pending flag is kept and reappears once the cause is enabled.
- R11: An `rd_iir` clears nothing except the cause whose code it returned.
- R12: When a cause's set pulse and its clearing action fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ien | input | 7 | Per-cause enable bits |
| fifo_en | input | 1 | FIFO mode select |
| rx_fpb_evt | input | 1 | Framing, parity or break error pulse |
| rx_oe_evt | input | 1 | Overrun error pulse |
| rx_stale_evt | input | 1 | Stale receive data pulse |
| rx_ready | input | 1 | Receive holding register full |
| rx_above_trig | input | 1 | RX FIFO above trigger level |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_below_trig | input | 1 | TX FIFO below trigger level |
| modem_chg_evt | input | 1 | Modem-status change pulse |
| xoff_evt | input | 1 | XOFF character detected |
| xon_evt | input | 1 | XON character detected |
| spec_evt | input | 1 | Special character matched |
| flow_pins | input | 3 | CTS, RTS, DSR levels (active low) |
| rd_data | input | 1 | Receive data register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| iid | output | 6 | Identification code of highest pending cause |
| irq | output | 1 | Interrupt request |

## Verification
Suppose a pending flag is wrong inside the block: a flag that fails to set, a flag that is wiped by the wrong strobe, or one that survives its own clear. The port code then differs in the cycle after the event or strobe edge, provided nothing of higher priority is pending. A flag hidden by a disabled enable stays invisible until that enable is restored. The bench therefore unmasks and re-reads the code before it clears masked flags. The bench model compares the code and the line in every cycle, so a wrong priority or a wrong FIFO-mode selection appears in the same cycle as the input that exposes it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 7;
  localparam int NFLAG  = 7;
  localparam int NPIN   = 3;
  localparam int IIDW   = 6;

  // source indices match enable bit positions
  localparam int S_LSTAT = 0;
  localparam int S_RXDAT = 1;
  localparam int S_TXEMP = 2;
  localparam int S_MODEM = 3;
  localparam int S_RXTMO = 4;
  localparam int S_FLOWC = 5;
  localparam int S_PINCH = 6;

  // sticky flag indices
  localparam int F_FPB  = 0;
  localparam int F_OE   = 1;
  localparam int F_TMO  = 2;
  localparam int F_MSR  = 3;
  localparam int F_XOFF = 4;
  localparam int F_SPEC = 5;
  localparam int F_PIN  = 6;

  localparam logic [IIDW-1:0] IID_NONE  = 6'b000001;
  localparam logic [IIDW-1:0] IID_LSTAT = 6'b000110;
  localparam logic [IIDW-1:0] IID_RXTMO = 6'b001100;
  localparam logic [IIDW-1:0] IID_RXDAT = 6'b000100;
  localparam logic [IIDW-1:0] IID_TXEMP = 6'b000010;
  localparam logic [IIDW-1:0] IID_MODEM = 6'b000000;
  localparam logic [IIDW-1:0] IID_FLOWC = 6'b010000;
  localparam logic [IIDW-1:0] IID_PINCH = 6'b100000;

  // code reported for a source
  function automatic logic [IIDW-1:0] src_code(input int s);
    case (s)
      S_LSTAT: return IID_LSTAT;
      S_RXTMO: return IID_RXTMO;
      S_RXDAT: return IID_RXDAT;
      S_TXEMP: return IID_TXEMP;
      S_MODEM: return IID_MODEM;
      S_FLOWC: return IID_FLOWC;
      S_PINCH: return IID_PINCH;
      default: return IID_NONE;
    endcase
  endfunction

  // source at priority rank r (0 = most urgent)
  function automatic int rank_src(input int r);
    case (r)
      0: return S_LSTAT;
      1: return S_RXTMO;
      2: return S_RXDAT;
      3: return S_TXEMP;
      4: return S_MODEM;
      5: return S_FLOWC;
      default: return S_PINCH;
    endcase
  endfunction

  // level source select by FIFO mode
  function automatic logic mode_level(input logic fifo_on, input logic single_flag,
                                      input logic fifo_flag);
    return fifo_on ? fifo_flag : single_flag;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[i] <= 1'b0;
      else if (set_i[i])   flag_o[i] <= 1'b1;
      else if (clr_i[i])   flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_pin_edge.sv
module flow_pin_edge #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  output logic [NPIN-1:0] rise_o
);
  logic [NPIN-1:0] prev_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= pins_i[i];
    end
    assign rise_o[i] = pins_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      pend_i,
  output logic [IIDW-1:0]   code_o
);
  always_comb begin
    code_o = IID_NONE;
    for (int r = N - 1; r >= 0; r--) begin
      if (pend_i[rank_src(r)]) code_o = src_code(rank_src(r));
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ien,
  input  logic            fifo_en,
  input  logic            rx_fpb_evt,
  input  logic            rx_oe_evt,
  input  logic            rx_stale_evt,
  input  logic            rx_ready,
  input  logic            rx_above_trig,
  input  logic            tx_hold_empty,
  input  logic            tx_below_trig,
  input  logic            modem_chg_evt,
  input  logic            xoff_evt,
  input  logic            xon_evt,
  input  logic            spec_evt,
  input  logic [NPIN-1:0] flow_pins,
  input  logic            rd_data,
  input  logic            rd_lsr,
  input  logic            rd_msr,
  input  logic            rd_iir,
  output logic [IIDW-1:0] iid,
  output logic            irq
);
  logic [NPIN-1:0]  pin_rise;
  logic             pin_rise_any;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;
  logic [NSRC-1:0]  pend_raw;
  logic [NSRC-1:0]  pend_masked;
  logic             spec_pend;
  logic             iir_ret_flowc;
  logic             iir_ret_pinch;

  flow_pin_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins_i(flow_pins), .rise_o(pin_rise)
  );

  assign pin_rise_any  = |pin_rise;
  assign iir_ret_flowc = rd_iir && (iid == IID_FLOWC);
  assign iir_ret_pinch = rd_iir && (iid == IID_PINCH);

  always_comb begin
    flag_set         = '0;
    flag_clr         = '0;
    flag_set[F_FPB]  = rx_fpb_evt;
    flag_clr[F_FPB]  = rd_data;
    flag_set[F_OE]   = rx_oe_evt;
    flag_clr[F_OE]   = rd_lsr;
    flag_set[F_TMO]  = rx_stale_evt;
    flag_clr[F_TMO]  = rd_data;
    flag_set[F_MSR]  = modem_chg_evt;
    flag_clr[F_MSR]  = rd_msr;
    flag_set[F_XOFF] = xoff_evt;
    flag_clr[F_XOFF] = xon_evt;
    flag_set[F_SPEC] = spec_evt;
    flag_clr[F_SPEC] = iir_ret_flowc;
    flag_set[F_PIN]  = pin_rise_any;
    flag_clr[F_PIN]  = iir_ret_pinch;
  end

  irq_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag_q)
  );

  assign spec_pend = flag_q[F_SPEC];

  always_comb begin
    pend_raw          = '0;
    pend_raw[S_LSTAT] = flag_q[F_FPB] | flag_q[F_OE];
    pend_raw[S_RXTMO] = flag_q[F_TMO];
    pend_raw[S_RXDAT] = mode_level(fifo_en, rx_ready, rx_above_trig);
    pend_raw[S_TXEMP] = mode_level(fifo_en, tx_hold_empty, tx_below_trig);
    pend_raw[S_MODEM] = flag_q[F_MSR];
    pend_raw[S_FLOWC] = flag_q[F_XOFF] | flag_q[F_SPEC];
    pend_raw[S_PINCH] = flag_q[F_PIN];
  end

  assign pend_masked = pend_raw & ien;

  irq_prio_enc #(.N(NSRC)) u_prio (
    .pend_i(pend_masked), .code_o(iid)
  );

  assign irq = ~iid[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ien,
  input logic            rx_fpb_evt,
  input logic            rx_stale_evt,
  input logic            modem_chg_evt,
  input logic            spec_evt,
  input logic            rd_data,
  input logic            rd_msr,
  input logic            rd_iir,
  input logic            pin_rise_any,
  input logic            spec_pend,
  input logic [NSRC-1:0] pend_masked,
  input logic [IIDW-1:0] iid,
  input logic            irq
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_masked == '0) |-> (iid == IID_NONE && !irq));

  p_ls_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fpb_evt && ien[S_LSTAT]) |=> (iid == IID_LSTAT));

  p_tmo_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_stale_evt) |=> (iid != IID_RXTMO));

  p_msr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !modem_chg_evt) |=> (iid != IID_MODEM));

  p_spec_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iid == IID_FLOWC && !spec_evt) |=> !spec_pend);

  p_pin_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rise_any && ien[S_PINCH]) |=> irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien(ien), .rx_fpb_evt(rx_fpb_evt),
  .rx_stale_evt(rx_stale_evt), .modem_chg_evt(modem_chg_evt), .spec_evt(spec_evt),
  .rd_data(rd_data), .rd_msr(rd_msr), .rd_iir(rd_iir), .pin_rise_any(pin_rise_any),
  .spec_pend(spec_pend), .pend_masked(pend_masked), .iid(iid), .irq(irq)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] ien = 7'h7f;
  logic       fifo_en = 0;
  logic       rx_fpb_evt = 0, rx_oe_evt = 0, rx_stale_evt = 0;
  logic       rx_ready = 0, rx_above_trig = 0, tx_hold_empty = 0, tx_below_trig = 0;
  logic       modem_chg_evt = 0, xoff_evt = 0, xon_evt = 0, spec_evt = 0;
  logic [2:0] flow_pins = 3'b000;
  logic       rd_data = 0, rd_lsr = 0, rd_msr = 0, rd_iir = 0;
  logic [5:0] iid;
  logic       irq;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  bit m_fpb, m_oe, m_tmo, m_msr, m_xoff, m_spec, m_pin;
  bit [2:0] m_prev = 3'b111;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ien(ien), .fifo_en(fifo_en),
    .rx_fpb_evt(rx_fpb_evt), .rx_oe_evt(rx_oe_evt), .rx_stale_evt(rx_stale_evt),
    .rx_ready(rx_ready), .rx_above_trig(rx_above_trig),
    .tx_hold_empty(tx_hold_empty), .tx_below_trig(tx_below_trig),
    .modem_chg_evt(modem_chg_evt), .xoff_evt(xoff_evt), .xon_evt(xon_evt),
    .spec_evt(spec_evt), .flow_pins(flow_pins), .rd_data(rd_data), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .rd_iir(rd_iir), .iid(iid), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit [5:0] model_code();
    bit rxd = fifo_en ? rx_above_trig : rx_ready;
    bit txe = fifo_en ? tx_below_trig : tx_hold_empty;
    if (ien[0] && (m_fpb || m_oe))   return 6'b000110;
    if (ien[4] && m_tmo)             return 6'b001100;
    if (ien[1] && rxd)               return 6'b000100;
    if (ien[2] && txe)               return 6'b000010;
    if (ien[3] && m_msr)             return 6'b000000;
    if (ien[5] && (m_xoff || m_spec)) return 6'b010000;
    if (ien[6] && m_pin)             return 6'b100000;
    return 6'b000001;
  endfunction

  task automatic compare();
    bit [5:0] exp_code = model_code();
    bit exp_irq = (exp_code != 6'b000001);
    checks++;
    if (iid !== exp_code || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", tag, iid, irq,
               exp_code, exp_irq);
    end
  endtask

  task automatic model_update();
    bit [5:0] ret = model_code();
    bit [2:0] rise = flow_pins & ~m_prev;
    m_fpb  = rx_fpb_evt    ? 1 : (rd_data ? 0 : m_fpb);
    m_oe   = rx_oe_evt     ? 1 : (rd_lsr ? 0 : m_oe);
    m_tmo  = rx_stale_evt  ? 1 : (rd_data ? 0 : m_tmo);
    m_msr  = modem_chg_evt ? 1 : (rd_msr ? 0 : m_msr);
    m_xoff = xoff_evt      ? 1 : (xon_evt ? 0 : m_xoff);
    m_spec = spec_evt      ? 1 : ((rd_iir && ret == 6'b010000) ? 0 : m_spec);
    m_pin  = (rise != 0)   ? 1 : ((rd_iir && ret == 6'b100000) ? 0 : m_pin);
    m_prev = flow_pins;
  endtask

  // inputs are changed only at negedge; compare then advance one clock
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      #1 compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic clear_pulses();
    rx_fpb_evt = 0; rx_oe_evt = 0; rx_stale_evt = 0; modem_chg_evt = 0;
    xoff_evt = 0; xon_evt = 0; spec_evt = 0;
    rd_data = 0; rd_lsr = 0; rd_msr = 0; rd_iir = 0;
  endtask

  task automatic expect_code(bit [5:0] exp_code, string t);
    #1;
    checks++;
    if (iid !== exp_code) begin
      errors++;
      $display("FAIL %s: iid=%b expected %b", t, iid, exp_code);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: iid=%b expected run to end", iid);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tag = "R1 reset";
    expect_code(6'b000001, "R1 reset state");
    tick(2);

    tag = "R5 rx data";
    rx_ready = 1; tick();
    expect_code(6'b000100, "R5 single mode");
    fifo_en = 1; tick();
    expect_code(6'b000001, "R5 fifo mode below trigger");
    rx_above_trig = 1; tick();
    rx_above_trig = 0; rx_ready = 0; fifo_en = 0; tick();

    tag = "R6 tx empty";
    tx_hold_empty = 1; tick();
    expect_code(6'b000010, "R6 single mode");
    fifo_en = 1; tick();
    tx_below_trig = 1; tick();
    tx_hold_empty = 0; tx_below_trig = 0; fifo_en = 0; tick();

    tag = "R4 timeout";
    rx_ready = 1; rx_stale_evt = 1; tick(); clear_pulses(); tick();
    expect_code(6'b001100, "R4 timeout over rx data");
    rd_data = 1; tick(); clear_pulses(); rx_ready = 0; tick();

    tag = "R3 line status";
    tx_hold_empty = 1;
    rx_fpb_evt = 1; tick(); clear_pulses();
    expect_code(6'b000110, "R3 fpb raised");
    rd_lsr = 1; tick(); clear_pulses();
    expect_code(6'b000110, "R3 lsr read keeps fpb");
    rd_data = 1; tick(); clear_pulses();
    rx_oe_evt = 1; tick(); clear_pulses();
    rd_data = 1; tick(); clear_pulses();
    expect_code(6'b000110, "R3 data read keeps overrun");
    rd_lsr = 1; tick(); clear_pulses();
    expect_code(6'b000010, "R3 overrun cleared");
    tx_hold_empty = 0; tick();

    tag = "R7 modem";
    modem_chg_evt = 1; tick(); clear_pulses(); tick();
    rd_iir = 1; tick(); clear_pulses();
    expect_code(6'b000000, "R7 iir read keeps modem");
    rd_msr = 1; tick(); clear_pulses(); tick();

    tag = "R8 xoff/special";
    xoff_evt = 1; tick(); clear_pulses();
    rd_iir = 1; tick(); clear_pulses();
    expect_code(6'b010000, "R8 iir read keeps xoff");
    xon_evt = 1; tick(); clear_pulses();
    spec_evt = 1; tick(); clear_pulses();
    rd_iir = 1; tick(); clear_pulses();
    expect_code(6'b000001, "R8 special cleared by iir read");
    xoff_evt = 1; spec_evt = 1; tick(); clear_pulses();
    rd_iir = 1; tick(); clear_pulses();
    expect_code(6'b010000, "R8 xoff survives iir read");
    xon_evt = 1; tick(); clear_pulses(); tick();

    tag = "R9 pin change";
    flow_pins = 3'b010; tick();
    expect_code(6'b100000, "R9 rts rise");
    rd_iir = 1; tick(); clear_pulses();
    flow_pins = 3'b000; tick();
    expect_code(6'b000001, "R9 falling edge ignored");
    flow_pins = 3'b100; tick(); flow_pins = 3'b000; tick();

    tag = "R11 iir selective";
    modem_chg_evt = 1; tick(); clear_pulses();
    rd_iir = 1; tick(); clear_pulses();
    rd_msr = 1; tick(); clear_pulses();
    expect_code(6'b100000, "R11 pin flag survived read of modem code");
    rd_iir = 1; tick(); clear_pulses(); tick();

    tag = "R10 masking";
    ien = 7'b111_0111;
    modem_chg_evt = 1; tick(); clear_pulses(); tick(2);
    expect_code(6'b000001, "R10 masked modem hidden");
    ien = 7'h7f; tick();
    expect_code(6'b000000, "R10 flag kept under mask");
    rd_msr = 1; tick(); clear_pulses();
    ien = 7'b011_1111; flow_pins = 3'b001; tick();
    rd_iir = 1; tick(); clear_pulses();
    ien = 7'h7f; tick();
    expect_code(6'b100000, "R10 R11 masked pin not cleared by iir read");
    rd_iir = 1; tick(); clear_pulses(); flow_pins = 3'b000; tick();

    tag = "R12 set wins";
    rx_fpb_evt = 1; rd_data = 1; tick(); clear_pulses();
    expect_code(6'b000110, "R12 set and clear together");
    rd_data = 1; tick(); clear_pulses();
    rx_stale_evt = 1; rd_data = 1; tick(); clear_pulses();
    expect_code(6'b001100, "R12 timeout set wins");
    rd_data = 1; tick(); clear_pulses();

    tag = "R2 line";
    tx_below_trig = 1; fifo_en = 1; tick(3);
    tx_below_trig = 0; tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule